// File: doc/BRIEF.md
# Eight-Window Ingress Address Translator

This block sits behind a bus bridge and rewrites 64-bit request addresses on their way to the local memory system. It holds eight translation windows. Each window has a source base, a destination base, a size code and an enable bit. A request whose upper address bits match an enabled window's source base leaves with those upper bits swapped for the window's destination base. The offset below the window boundary passes through untouched. Window size is a power of two counted from a 4 KB granule, so the bit position that separates compared bits from kept bits moves with the size code.

Software sets up each window through a plain 32-bit register port. It writes the two base addresses as low and high words, then writes the control word last. Requests that the bridge has already classified as interrupt messages or internal DMA traffic carry a bypass flag and leave the block unaltered.

The request path is a valid/ready stream with no storage. The response is a combinational function of the request and the registered window configuration. `rsp_valid` follows `req_valid`, and `req_ready` follows `rsp_ready`. Back-pressure from the consumer therefore stalls the producer in the same cycle, and a request is taken only on a cycle where both valid and ready are high.

Top module: `ingress_xlat`

## Requirements
- R1: The register address `reg_addr` is split into two fields. Bits [6:3] carry the window index and bits [2:0] carry the register select. The select codes are 0 = source base low word, 1 = source base high word, 2 = destination base low word, 3 = destination base high word and 4 = control. A window index above 7 or a select of 5 to 7 is rejected: `reg_err` is high while `reg_wr` or `reg_rd` is high, a rejected write changes no window, and `reg_rdata` reads 0.
- R2: A write to a source base low word stores bits [3:0] as zero. Readback shows those bits as zero.
- R3: The control word holds the enable flag in bit 0 and a 6-bit size code in bits [13:8]. All other control bits read as 0. A register write changes translation from the clock edge that takes it onward, not before.
- R4: After reset, every register of every window reads 0, and no window is enabled.
- R5: A window hits only when it is enabled and bits [63:12+s] of its source base equal the same bits of the request, where s is its effective size code.
- R6: On a hit, bits [63:12+s] of `rsp_addr` come from the destination base and the bits below come from the request. For example, source 0xFFA0_0000, destination 0x44A0_0000 and size 4 map request 0xFFA0_1234 to 0x44A0_1234.
- R7: Size code 0 gives a 4 KB window, and each step up doubles the window size. A size code above 51 behaves exactly as 51, so only bit 63 is compared and replaced.
- R8: When several enabled windows hit, the lowest-numbered window wins. `rsp_win` reports its index.
- R9: When no window hits, `rsp_addr` equals `req_addr`, `rsp_hit` is 0 and `rsp_win` is 0.
- R10: When `req_bypass` is high, `rsp_addr` equals `req_addr`, `rsp_hit` is 0 and `rsp_win` is 0, whatever the window contents.
- R11: `rsp_valid` equals `req_valid` and `req_ready` equals `rsp_ready` in every cycle. The response fields reflect the request presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (qualifies `reg_err`) |
| reg_addr | input | 7 | Register address: window index [6:3], select [2:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| reg_err | output | 1 | Access names a window or select that does not exist |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_addr | input | 64 | Request address |
| req_bypass | input | 1 | Request skips translation (interrupt message or internal DMA) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer ready |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 3 | Index of the matching window, 0 on a miss |

## Verification
The hardest case to reach from the ports is two enabled windows that overlap the same request. Only that case shows whether the priority goes to the lower index. The stimulus programs windows 2 and 5 with the same source region and different destinations, then disables window 2 so that window 5 must take over.

Clamped size codes are also easy to miss. A code of 63 is compared against a code of 51 on a request that has bit 63 set. A write that a broken decoder would alias onto window 0, and a control word written last in a partly programmed window, complete the set. A behavioural model in the bench is compared with the response on every clock.

// File: rtl/ixl_pkg.sv
package ixl_pkg;

  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned SIZE_W     = 6;
  localparam int unsigned GRAN_SHIFT = 12;
  localparam int unsigned MAX_SIZE   = ADDR_W - 1 - GRAN_SHIFT;  // 51
  localparam int unsigned CTRL_EN    = 0;
  localparam int unsigned CTRL_SZ_LO = 8;

  typedef enum logic [2:0] {
    SEL_SRC_LO = 3'd0,
    SEL_SRC_HI = 3'd1,
    SEL_DST_LO = 3'd2,
    SEL_DST_HI = 3'd3,
    SEL_CTRL   = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [SIZE_W-1:0] size;
    logic              en;
  } win_cfg_t;

endpackage

// File: rtl/ixl_regbank.sv
module ixl_regbank
  import ixl_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int IDXW = $clog2(NWIN),
  localparam int RA_W = IDXW + 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [RA_W-1:0]       reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  reg_err,
  output win_cfg_t [NWIN-1:0]   cfg_o
);

  localparam int WIDX_W = RA_W - 3;

  logic [WIDX_W-1:0] widx;
  reg_sel_e          sel;
  logic              addr_ok;

  assign widx    = reg_addr[RA_W-1:3];
  assign sel     = reg_sel_e'(reg_addr[2:0]);
  assign addr_ok = (int'(widx) < NWIN) && (reg_addr[2:0] <= 3'(SEL_CTRL));
  assign reg_err = (reg_wr || reg_rd) && !addr_ok;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [SIZE_W-1:0] size_q;
    logic              en_q;
    logic              we;

    assign we = reg_wr && addr_ok && (widx == WIDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q  <= '0;
        dst_q  <= '0;
        size_q <= '0;
        en_q   <= 1'b0;
      end else if (we) begin
        case (sel)
          SEL_SRC_LO: src_q[31:0]  <= {reg_wdata[31:4], 4'b0000};
          SEL_SRC_HI: src_q[63:32] <= reg_wdata;
          SEL_DST_LO: dst_q[31:0]  <= reg_wdata;
          SEL_DST_HI: dst_q[63:32] <= reg_wdata;
          SEL_CTRL: begin
            size_q <= reg_wdata[CTRL_SZ_LO +: SIZE_W];
            en_q   <= reg_wdata[CTRL_EN];
          end
          default: ;
        endcase
      end
    end

    assign cfg_o[w] = '{src: src_q, dst: dst_q, size: size_q, en: en_q};
  end

  win_cfg_t rcfg;

  always_comb begin
    rcfg      = cfg_o[widx[IDXW-1:0]];
    reg_rdata = '0;
    if (addr_ok) begin
      case (sel)
        SEL_SRC_LO: reg_rdata = rcfg.src[31:0];
        SEL_SRC_HI: reg_rdata = rcfg.src[63:32];
        SEL_DST_LO: reg_rdata = rcfg.dst[31:0];
        SEL_DST_HI: reg_rdata = rcfg.dst[63:32];
        SEL_CTRL: begin
          reg_rdata[CTRL_SZ_LO +: SIZE_W] = rcfg.size;
          reg_rdata[CTRL_EN]              = rcfg.en;
        end
        default: reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/ixl_win_match.sv
module ixl_win_match
  import ixl_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [SIZE_W-1:0] size_eff;
  logic [6:0]        split;
  logic [ADDR_W-1:0] keep_mask;

  always_comb begin
    size_eff  = (cfg.size > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : cfg.size;
    split     = 7'(GRAN_SHIFT) + {1'b0, size_eff};
    keep_mask = ({{(ADDR_W-1){1'b0}}, 1'b1} << split) - {{(ADDR_W-1){1'b0}}, 1'b1};
    hit_o     = cfg.en && (((cfg.src ^ addr_i) & ~keep_mask) == '0);
    addr_o    = (cfg.dst & ~keep_mask) | (addr_i & keep_mask);
  end

endmodule

// File: rtl/ixl_prio_sel.sv
module ixl_prio_sel
  import ixl_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int IDXW = $clog2(NWIN)
) (
  input  logic [NWIN-1:0]              hit_v,
  input  logic [NWIN-1:0][ADDR_W-1:0]  xaddr_v,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic                         bypass,
  output logic                         hit_o,
  output logic [IDXW-1:0]              idx_o,
  output logic [ADDR_W-1:0]            addr_o
);

  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    addr_o = req_addr;
    // Scan from the top so the lowest index is the last to take effect.
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        hit_o  = 1'b1;
        idx_o  = IDXW'(i);
        addr_o = xaddr_v[i];
      end
    end
    if (bypass) begin
      hit_o  = 1'b0;
      idx_o  = '0;
      addr_o = req_addr;
    end
  end

endmodule

// File: rtl/ingress_xlat.sv
module ingress_xlat
  import ixl_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int IDXW = $clog2(NWIN),
  localparam int RA_W = IDXW + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_addr,
  input  logic              req_bypass,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_addr,
  output logic              rsp_hit,
  output logic [IDXW-1:0]   rsp_win
);

  win_cfg_t [NWIN-1:0]             win_cfg;
  logic [NWIN-1:0]                 hit_v;
  logic [NWIN-1:0][ADDR_W-1:0]     xaddr_v;

  ixl_regbank #(.NWIN(NWIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .reg_err   (reg_err),
    .cfg_o     (win_cfg)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_match
    ixl_win_match u_match (
      .cfg    (win_cfg[w]),
      .addr_i (req_addr),
      .hit_o  (hit_v[w]),
      .addr_o (xaddr_v[w])
    );
  end

  ixl_prio_sel #(.NWIN(NWIN)) u_sel (
    .hit_v    (hit_v),
    .xaddr_v  (xaddr_v),
    .req_addr (req_addr),
    .bypass   (req_bypass),
    .hit_o    (rsp_hit),
    .idx_o    (rsp_win),
    .addr_o   (rsp_addr)
  );

  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;

endmodule

// File: rtl/ixl_chk.sv
module ixl_chk
  import ixl_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int IDXW = $clog2(NWIN),
  localparam int RA_W = IDXW + 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic                 reg_err,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [63:0]          req_addr,
  input logic                 req_bypass,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [63:0]          rsp_addr,
  input logic                 rsp_hit,
  input logic [IDXW-1:0]      rsp_win,
  input win_cfg_t [NWIN-1:0]  win_cfg
);

  // R1
  rejected_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_err) |=> $stable(win_cfg));

  // R3
  cfg_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(win_cfg));

  for (genvar w = 0; w < NWIN; w++) begin : g_lo
    // R2
    src_low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_cfg[w].src[3:0] == 4'h0);
  end

  // R5
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> win_cfg[rsp_win].en);

  // R7
  granule_offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_addr[11:0] == req_addr[11:0]));

  // R9
  miss_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_addr == req_addr && rsp_win == '0));

  // R10
  bypass_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_bypass |-> (!rsp_hit && rsp_addr == req_addr));

  // R11
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == req_valid);

endmodule

bind ingress_xlat ixl_chk #(.NWIN(NWIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_err    (reg_err),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_bypass (req_bypass),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_addr   (rsp_addr),
  .rsp_hit    (rsp_hit),
  .rsp_win    (rsp_win),
  .win_cfg    (win_cfg)
);

// File: tb/sim_ingress_xlat.sv
`timescale 1ns/1ps
module sim_ingress_xlat;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        req_valid = 1'b0, req_bypass = 1'b0, rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, rsp_hit;
  logic [63:0] req_addr = '0, rsp_addr;
  logic [2:0]  rsp_win;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  string cur_tag = "R4";

  // Behavioural model state
  logic [63:0] m_src [8];
  logic [63:0] m_dst [8];
  int          m_size [8];
  bit          m_en [8];

  always #2.5 clk = ~clk;

  ingress_xlat u0 (.*);

  function automatic void model(input logic [63:0] a, input bit byp,
                                output bit h, output int w, output logic [63:0] o);
    h = 0; w = 0; o = a;
    if (byp) return;
    for (int i = 0; i < 8; i++) begin
      int s = (m_size[i] > 51) ? 51 : m_size[i];
      int k = 12 + s;
      if (m_en[i] && ((m_src[i] >> k) == (a >> k))) begin
        h = 1; w = i;
        o = ((m_dst[i] >> k) << k) | (a & ((64'd1 << k) - 64'd1));
        return;
      end
    end
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      bit h; int w; logic [63:0] o;
      model(req_addr, req_bypass, h, w, o);
      check(cur_tag, "rsp_addr", rsp_addr, o);
      check(cur_tag, "rsp_hit", 64'(rsp_hit), 64'(h));
      check(cur_tag, "rsp_win", 64'(rsp_win), 64'(w));
      check("R11", "rsp_valid", 64'(rsp_valid), 64'(req_valid));
      check("R11", "req_ready", 64'(req_ready), 64'(rsp_ready));
    end
  end

  task automatic summary();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL R11 watchdog actual=%0d expected<=20000", cyc);
      summary();
    end
  end

  function automatic bit addr_valid(input logic [6:0] a);
    return (a[6:3] < 4'd8) && (a[2:0] < 3'd5);
  endfunction

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    #0.5;
    check("R1", "reg_err on write", 64'(reg_err), 64'(!addr_valid(a)));
    @(posedge clk); #1;
    reg_wr = 0;
    if (addr_valid(a)) begin
      int w = int'(a[5:3]);
      case (a[2:0])
        3'd0: m_src[w][31:0]  = d & 32'hFFFF_FFF0;
        3'd1: m_src[w][63:32] = d;
        3'd2: m_dst[w][31:0]  = d;
        3'd3: m_dst[w][63:32] = d;
        default: begin m_size[w] = int'(d[13:8]); m_en[w] = d[0]; end
      endcase
    end
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #0.5;
    check(tag, "reg_rdata", 64'(reg_rdata), 64'(exp));
    check(tag, "reg_err on read", 64'(reg_err), 64'(!addr_valid(a)));
    reg_rd = 0;
  endtask

  task automatic req(input logic [63:0] a, input bit byp, input string tag,
                     input bit eh, input int ew, input logic [63:0] ea);
    @(negedge clk);
    cur_tag = tag; req_valid = 1; req_addr = a; req_bypass = byp;
    #0.5;
    check(tag, "literal addr", rsp_addr, ea);
    check(tag, "literal hit", 64'(rsp_hit), 64'(eh));
    check(tag, "literal win", 64'(rsp_win), 64'(ew));
  endtask

  function automatic logic [6:0] ra(input int w, input int s);
    return 7'((w << 3) | s);
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_src[i] = '0; m_dst[i] = '0; m_size[i] = 0; m_en[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R4: reset state
    for (int s = 0; s < 5; s++) begin
      rd(ra(0, s), 32'h0, "R4");
      rd(ra(7, s), 32'h0, "R4");
    end
    req(64'h0, 0, "R4", 0, 0, 64'h0);

    // R2, R3: program window 0, control last
    wr(ra(0, 0), 32'hFFA0_000F);
    rd(ra(0, 0), 32'hFFA0_0000, "R2");
    wr(ra(0, 1), 32'h0);
    wr(ra(0, 2), 32'h44A0_0000);
    wr(ra(0, 3), 32'h0);
    req(64'hFFA0_1234, 0, "R3", 0, 0, 64'hFFA0_1234);
    wr(ra(0, 4), 32'hF0F0_0401);
    rd(ra(0, 4), 32'h0000_0401, "R3");

    // R6 worked example, R7 window extent, R5 compare
    req(64'hFFA0_1234, 0, "R6", 1, 0, 64'h44A0_1234);
    req(64'hFFA0_FFFF, 0, "R7", 1, 0, 64'h44A0_FFFF);
    req(64'hFFA1_0000, 0, "R7", 0, 0, 64'hFFA1_0000);
    req(64'hFFB0_1234, 0, "R5", 0, 0, 64'hFFB0_1234);
    req(64'h1_FFA0_1234, 0, "R5", 0, 0, 64'h1_FFA0_1234);

    // R10 bypass
    req(64'hFFA0_1234, 1, "R10", 0, 0, 64'hFFA0_1234);

    // R5 disable
    wr(ra(0, 4), 32'h0000_0400);
    req(64'hFFA0_1234, 0, "R5", 0, 0, 64'hFFA0_1234);

    // R8 overlapping windows 2 and 5
    wr(ra(2, 1), 32'h1); wr(ra(2, 2), 32'hA000_0000); wr(ra(2, 4), 32'h0801);
    wr(ra(5, 1), 32'h1); wr(ra(5, 2), 32'hB000_0000); wr(ra(5, 4), 32'h0801);
    req(64'h1_0000_5678, 0, "R8", 1, 2, 64'hA000_5678);
    wr(ra(2, 4), 32'h0800);
    req(64'h1_0000_5678, 0, "R8", 1, 5, 64'hB000_5678);
    req(64'h1_0010_0000, 0, "R9", 0, 0, 64'h1_0010_0000);

    // R7 clamp: size 63 and 51 both split at bit 63
    wr(ra(7, 1), 32'h8000_0000); wr(ra(7, 4), 32'h3F01);
    req(64'h8123_4567_89AB_CDEF, 0, "R7", 1, 7, 64'h0123_4567_89AB_CDEF);
    req(64'h0123_4567_89AB_CDEF, 0, "R7", 0, 0, 64'h0123_4567_89AB_CDEF);
    wr(ra(7, 4), 32'h3301);
    req(64'h8000_0000_0000_0001, 0, "R7", 1, 7, 64'h0000_0000_0000_0001);

    // R1 rejected accesses
    wr(7'h40, 32'hDEAD_BEEF);
    rd(ra(0, 0), 32'hFFA0_0000, "R1");
    wr(ra(1, 5), 32'h1234_5678);
    rd(ra(1, 5), 32'h0, "R1");
    rd(7'h48, 32'h0, "R1");
    rd(ra(1, 0), 32'h0, "R1");

    // R11 back-pressure
    @(negedge clk); rsp_ready = 0; cur_tag = "R11";
    #0.5; check("R11", "req_ready low", 64'(req_ready), 64'(0));
    @(negedge clk); req_valid = 0; rsp_ready = 1;
    #0.5; check("R11", "rsp_valid low", 64'(rsp_valid), 64'(0));

    repeat (3) @(posedge clk);
    #4;
    summary();
  end

endmodule